// File: doc/BRIEF.md
# Banked Register File with Two-Group Exchange

This block is the 8-bit CPU's working register file. It holds four 16-bit register pairs (accumulator/flags, and three general pairs). Each pair has a second, hidden copy. Two exchange commands trade the visible and hidden copies. One command trades only the accumulator/flags pair. The other trades all three general pairs at once. A separate set of four unbanked 16-bit registers holds the two index values, the stack pointer and the program counter, and no exchange ever touches them.

The block looks at the opcode stream only far enough to spot the two exchange opcodes. A single pair port, addressed by a 2-bit selector, reads and writes whichever copy of the named pair is visible. No output shows which copy is visible. Software can only infer it from the data.

Top module: `shadow_regfile`

## Requirements
- R1: An accepted opcode 0x08 exchanges the accumulator/flags pair with its hidden copy and leaves BC, DE and HL unchanged.
- R2: An accepted opcode 0xD9 exchanges BC, DE and HL with their hidden copies together in one operation and leaves the accumulator/flags pair unchanged.
- R3: The unbanked registers (ctl_sel 00=IX, 01=IY, 10=SP, 11=PC) keep their values across both exchanges. They change only through their own write port.
- R4: The pair port uses pair_sel 00=BC, 01=DE, 10=HL, 11=AF. A write takes effect at the clock edge. pair_rd_data shows the visible copy of the selected pair without delay.
- R5: A pair write in the same cycle as an exchange lands in the copy that was visible before that exchange.
- R6: An opcode is accepted only while op_valid is 1. Any other opcode, or either exchange opcode with op_valid at 0, leaves every register unchanged.
- R7: Reset (rst_n low) zeroes every register, visible and hidden, and makes the main copies visible.
- R8: Two exchanges of the same group with no writes between them restore the group's original visible contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | op_code holds an issued opcode this cycle |
| op_code | input | 8 | Opcode byte under decode |
| pair_sel | input | 2 | Pair select: 00=BC, 01=DE, 10=HL, 11=AF |
| pair_wr_en | input | 1 | Write pair_wr_data into the selected pair |
| pair_wr_data | input | 16 | Pair write data |
| pair_rd_data | output | 16 | Visible contents of the selected pair |
| ctl_sel | input | 2 | Unbanked select: 00=IX, 01=IY, 10=SP, 11=PC |
| ctl_wr_en | input | 1 | Write ctl_wr_data into the selected unbanked register |
| ctl_wr_data | input | 16 | Unbanked write data |
| ctl_rd_data | output | 16 | Contents of the selected unbanked register |

## Verification
The bench uses the default parameters: 16-bit pairs and exchange opcodes 0x08 and 0xD9. With these values every register path can be reached from the ports. The bench can therefore drive each exchange opcode next to a near-miss opcode and a gated strobe. It can pair an exchange with a write in the same cycle in each group, and it can swap a group twice to show the original contents come back. Distinct data patterns in each pair expose a swap that reaches the wrong group, or a write that lands in the wrong copy.

// File: rtl/shadow_regfile_pkg.sv
package shadow_regfile_pkg;
  typedef enum logic [1:0] {
    PAIR_BC = 2'b00,
    PAIR_DE = 2'b01,
    PAIR_HL = 2'b10,
    PAIR_AF = 2'b11
  } pair_e;

  // True when an issued opcode matches the target opcode
  function automatic logic op_hit(input logic vld, input logic [7:0] code,
                                  input logic [7:0] target);
    return vld && (code == target);
  endfunction

  // Selects the visible copy given the group's select state
  function automatic logic [15:0] pick_copy(input logic alt,
                                            input logic [15:0] main_v,
                                            input logic [15:0] alt_v);
    return alt ? alt_v : main_v;
  endfunction
endpackage

// File: rtl/xchg_decode.sv
module xchg_decode
  import shadow_regfile_pkg::*;
#(
  parameter logic [7:0] OP_ACC = 8'h08,
  parameter logic [7:0] OP_GEN = 8'hD9
) (
  input  logic       op_valid,
  input  logic [7:0] op_code,
  output logic       swap_acc,
  output logic       swap_gen
);
  always_comb begin
    swap_acc = op_hit(op_valid, op_code, OP_ACC);
    swap_gen = op_hit(op_valid, op_code, OP_GEN);
  end
endmodule

// File: rtl/xchg_bank.sv
module xchg_bank
  import shadow_regfile_pkg::*;
#(
  parameter int NPAIRS = 3,
  parameter int W      = 16,
  localparam int IDX_W = (NPAIRS > 1) ? $clog2(NPAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [W-1:0]      wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [W-1:0]      rd_data,
  output logic [NPAIRS*W-1:0] vis_flat
);
  logic [W-1:0] copy_m [NPAIRS];
  logic [W-1:0] copy_a [NPAIRS];
  logic         alt_q;

  // The select flop steers accesses; externally this equals a content swap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alt_q <= 1'b0;
      for (int i = 0; i < NPAIRS; i++) begin
        copy_m[i] <= '0;
        copy_a[i] <= '0;
      end
    end else begin
      if (swap) alt_q <= ~alt_q;
      if (wr_en && (int'(wr_idx) < NPAIRS)) begin
        if (alt_q) copy_a[wr_idx] <= wr_data;
        else       copy_m[wr_idx] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPAIRS; i++)
      if (int'(rd_idx) == i) rd_data = pick_copy(alt_q, copy_m[i], copy_a[i]);
  end

  for (genvar g = 0; g < NPAIRS; g++) begin : g_vis
    assign vis_flat[g*W +: W] = pick_copy(alt_q, copy_m[g], copy_a[g]);
  end
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs #(
  parameter int W    = 16,
  parameter int NREG = 4,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  output logic [NREG*W-1:0] vis_flat
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[sel] <= wr_data;
    end
  end

  assign rd_data = regs_q[sel];

  for (genvar g = 0; g < NREG; g++) begin : g_vis
    assign vis_flat[g*W +: W] = regs_q[g];
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import shadow_regfile_pkg::*;
#(
  parameter int         DATA_W = 16,
  parameter logic [7:0] OP_ACC = 8'h08,
  parameter logic [7:0] OP_GEN = 8'hD9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic [1:0]        pair_sel,
  input  logic              pair_wr_en,
  input  logic [DATA_W-1:0] pair_wr_data,
  output logic [DATA_W-1:0] pair_rd_data,
  input  logic [1:0]        ctl_sel,
  input  logic              ctl_wr_en,
  input  logic [DATA_W-1:0] ctl_wr_data,
  output logic [DATA_W-1:0] ctl_rd_data
);
  localparam int GEN_PAIRS = 3;

  // Internal events brought out for the checker
  logic                          swap_acc, swap_gen;
  logic                          sel_is_acc;
  logic [DATA_W-1:0]             acc_rd, gen_rd;
  logic [DATA_W-1:0]             acc_vis;
  logic [GEN_PAIRS*DATA_W-1:0]   gen_vis;
  logic [4*DATA_W-1:0]           ctl_vis;

  assign sel_is_acc = (pair_sel == PAIR_AF);

  xchg_decode #(.OP_ACC(OP_ACC), .OP_GEN(OP_GEN)) u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .swap_acc (swap_acc),
    .swap_gen (swap_gen)
  );

  xchg_bank #(.NPAIRS(1), .W(DATA_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap     (swap_acc),
    .wr_en    (pair_wr_en && sel_is_acc),
    .wr_idx   (1'b0),
    .wr_data  (pair_wr_data),
    .rd_idx   (1'b0),
    .rd_data  (acc_rd),
    .vis_flat (acc_vis)
  );

  xchg_bank #(.NPAIRS(GEN_PAIRS), .W(DATA_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap     (swap_gen),
    .wr_en    (pair_wr_en && !sel_is_acc),
    .wr_idx   (pair_sel),
    .wr_data  (pair_wr_data),
    .rd_idx   (pair_sel),
    .rd_data  (gen_rd),
    .vis_flat (gen_vis)
  );

  ctl_regs #(.W(DATA_W), .NREG(4)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (ctl_sel),
    .wr_en    (ctl_wr_en),
    .wr_data  (ctl_wr_data),
    .rd_data  (ctl_rd_data),
    .vis_flat (ctl_vis)
  );

  assign pair_rd_data = sel_is_acc ? acc_rd : gen_rd;
endmodule

// File: rtl/shadow_regfile_chk.sv
module shadow_regfile_chk #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                swap_acc,
  input logic                swap_gen,
  input logic                pair_wr_en,
  input logic [1:0]          pair_sel,
  input logic [DATA_W-1:0]   pair_wr_data,
  input logic                ctl_wr_en,
  input logic [DATA_W-1:0]   acc_vis,
  input logic [3*DATA_W-1:0] gen_vis,
  input logic [4*DATA_W-1:0] ctl_vis
);
  // R1
  acc_swap_keeps_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_acc && !swap_gen && !pair_wr_en) |=> $stable(gen_vis));

  // R2
  gen_swap_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_gen && !swap_acc && !pair_wr_en) |=> $stable(acc_vis));

  // R3
  ctl_unbanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr_en) |=> $stable(ctl_vis));

  // R4
  acc_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_wr_en && pair_sel == 2'b11 && !swap_acc) |=> (acc_vis == $past(pair_wr_data)));

  // R6
  decode_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_acc && swap_gen));

  // R8
  acc_double_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_acc && !pair_wr_en) ##1 (swap_acc && !pair_wr_en) |=> (acc_vis == $past(acc_vis, 2)));
endmodule

bind shadow_regfile shadow_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .swap_acc     (swap_acc),
  .swap_gen     (swap_gen),
  .pair_wr_en   (pair_wr_en),
  .pair_sel     (pair_sel),
  .pair_wr_data (pair_wr_data),
  .ctl_wr_en    (ctl_wr_en),
  .acc_vis      (acc_vis),
  .gen_vis      (gen_vis),
  .ctl_vis      (ctl_vis)
);

// File: tb/sim_shadow_regfile.sv
module sim_shadow_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  op_code;
  logic [1:0]  pair_sel;
  logic        pair_wr_en;
  logic [15:0] pair_wr_data;
  logic [15:0] pair_rd_data;
  logic [1:0]  ctl_sel;
  logic        ctl_wr_en;
  logic [15:0] ctl_wr_data;
  logic [15:0] ctl_rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  shadow_regfile u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .pair_sel(pair_sel), .pair_wr_en(pair_wr_en), .pair_wr_data(pair_wr_data),
    .pair_rd_data(pair_rd_data), .ctl_sel(ctl_sel), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data)
  );

  // {op_valid, op_code, wr_en, sel, wdata, expected read of sel after the edge, req tag}
  typedef struct packed {
    logic        vld;
    logic [7:0]  op;
    logic        we;
    logic [1:0]  sel;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b1, 2'b11, 16'h1111, 16'h1111, 4'd4},  // R4 write AF
    '{1'b0, 8'h00, 1'b1, 2'b00, 16'h2222, 16'h2222, 4'd4},  // R4 write BC
    '{1'b0, 8'h00, 1'b1, 2'b01, 16'h3333, 16'h3333, 4'd4},  // R4 write DE
    '{1'b0, 8'h00, 1'b1, 2'b10, 16'h4444, 16'h4444, 4'd4},  // R4 write HL
    '{1'b1, 8'h08, 1'b0, 2'b11, 16'h0000, 16'h0000, 4'd1},  // R1 AF hidden
    '{1'b0, 8'h00, 1'b1, 2'b11, 16'hAAAA, 16'hAAAA, 4'd1},  // R1 write hidden AF
    '{1'b1, 8'hD9, 1'b0, 2'b00, 16'h0000, 16'h0000, 4'd2},  // R2 BC hidden
    '{1'b0, 8'h00, 1'b0, 2'b01, 16'h0000, 16'h0000, 4'd2},  // R2 DE hidden too
    '{1'b0, 8'h00, 1'b1, 2'b10, 16'h5555, 16'h5555, 4'd2},  // R2 write hidden HL
    '{1'b1, 8'h08, 1'b0, 2'b11, 16'h0000, 16'h1111, 4'd8},  // R8 AF main back
    '{1'b1, 8'h08, 1'b0, 2'b00, 16'h0000, 16'h0000, 4'd1},  // R1 BC untouched
    '{1'b1, 8'hD9, 1'b0, 2'b10, 16'h0000, 16'h4444, 4'd8},  // R8 HL main back
    '{1'b1, 8'hD9, 1'b1, 2'b01, 16'h6666, 16'h0000, 4'd5},  // R5 write to main DE
    '{1'b1, 8'hD9, 1'b0, 2'b01, 16'h0000, 16'h6666, 4'd5},  // R5 main DE holds it
    '{1'b1, 8'h00, 1'b0, 2'b11, 16'h0000, 16'hAAAA, 4'd6},  // R6 other opcode
    '{1'b0, 8'h08, 1'b0, 2'b11, 16'h0000, 16'hAAAA, 4'd6},  // R6 gated strobe
    '{1'b1, 8'h08, 1'b1, 2'b11, 16'h7777, 16'h1111, 4'd5},  // R5 write to hidden AF
    '{1'b1, 8'h08, 1'b0, 2'b11, 16'h0000, 16'h7777, 4'd5}   // R5 hidden AF holds it
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 1'b0; op_code = 8'h00; pair_wr_en = 1'b0; ctl_wr_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    idle();
    rst_n = 1'b0; pair_sel = 2'b00; pair_wr_data = '0; ctl_sel = 2'b00; ctl_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state: all pairs zero
    for (int s = 0; s < 4; s++) begin
      pair_sel = s[1:0];
      #1 check("R7", pair_rd_data, 16'h0000);
    end

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      op_valid = VECS[i].vld; op_code = VECS[i].op; pair_wr_en = VECS[i].we;
      pair_sel = VECS[i].sel; pair_wr_data = VECS[i].wd;
      step();
      idle();
      #1 check($sformatf("R%0d vec%0d", VECS[i].req, i), pair_rd_data, VECS[i].exp);
    end

    // R3 unbanked registers across both exchanges
    for (int s = 0; s < 4; s++) begin
      ctl_sel = s[1:0]; ctl_wr_en = 1'b1; ctl_wr_data = 16'hC000 + 16'(s * 16'h0101);
      step();
    end
    idle();
    op_valid = 1'b1; op_code = 8'h08; step();
    op_code = 8'hD9; step();
    idle();
    for (int s = 0; s < 4; s++) begin
      ctl_sel = s[1:0];
      #1 check("R3", ctl_rd_data, 16'hC000 + 16'(s * 16'h0101));
    end

    // R7 reset mid-run clears hidden copies and selects main
    rst_n = 1'b0; step(); rst_n = 1'b1;
    pair_sel = 2'b11;
    #1 check("R7 AF", pair_rd_data, 16'h0000);
    ctl_sel = 2'b11;
    #1 check("R7 PC", ctl_rd_data, 16'h0000);
    pair_wr_en = 1'b1; pair_wr_data = 16'h1234; step(); idle();
    op_valid = 1'b1; op_code = 8'h08; step(); idle();
    #1 check("R7 hidden AF zero", pair_rd_data, 16'h0000);
    op_valid = 1'b1; op_code = 8'h08; step(); idle();
    #1 check("R7 main AF", pair_rd_data, 16'h1234);
    pair_sel = 2'b00; pair_wr_en = 1'b1; pair_wr_data = 16'hBEEF; step(); idle();
    op_valid = 1'b1; op_code = 8'hD9; step(); idle();
    #1 check("R7 hidden BC zero", pair_rd_data, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule